// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble

This block serialises data written into a one-entry holding register onto a single transmit line. A frame is a low start bit, eight data bits (or nine when the width select is high) sent least significant bit first, and a high stop bit. Each bit lasts from one `bit_tick` pulse to the next. An external baud generator supplies the tick. A flag tells software when the holding register can take another byte.

The enable input governs the line. When the transmitter is first enabled it sends one idle character, which is a run of high bits as long as a frame, before any data. If the enable is dropped and raised again while a frame is still on the line, that frame completes and one idle character follows it. If the enable is still low when a frame ends, the block stops driving the pin, and any byte left waiting in the holding register is thrown away.

The controller has four states: `ST_OFF`, where the pin is released; `ST_IDLECH`, which sends an idle character; `ST_READY`, which enables the pin and holds the line high; and `ST_SEND`, which shifts a frame. The transitions are as follows:
- `ST_OFF` goes to `ST_IDLECH` on a tick while enabled (the preamble).
- `ST_IDLECH` ends on its last-bit tick. It goes to `ST_SEND` if a byte is waiting, to `ST_READY` if none is, and to `ST_OFF` if disabled.
- `ST_READY` goes to `ST_SEND` on a tick with a byte waiting. It goes to `ST_OFF` as soon as the enable is low.
- `ST_SEND` ends on its last-bit tick. It goes to `ST_OFF` if disabled, to `ST_IDLECH` if the enable was low at some point during the frame, back to `ST_SEND` if another byte is waiting, and otherwise to `ST_READY`.

Top module: `sertx_idle`

## Requirements
- R1: After reset the pin is released (`tx_oe` = 0), `tx_line` is 1 and `buf_empty` is 1. Whenever `tx_oe` is 0, `tx_line` is 1.
- R2: A frame is: bit 0 = 0 (start), then data bits 0..7 (`mode9` = 0) or 0..8 (`mode9` = 1) LSB first, then one stop bit = 1. Each bit is held for exactly one tick interval, and the line does not change between ticks.
- R3: An idle character is all 1s and lasts 10 tick intervals when `mode9` = 0 and 11 when `mode9` = 1.
- R4: On the first tick after being enabled from the released state, the block sends one idle character as a preamble before any frame.
- R5: A write clears `buf_empty` on the next clock. Moving the held byte into the shifter sets `buf_empty`, unless a write occurs in the same cycle.
- R6: If a byte is waiting when a stop bit or idle character ends, its start bit follows with no gap. A byte that arrives while the line is idle starts on the next tick.
- R7: If the enable is low when a frame ends, the frame still completes in full with the pin enabled. `tx_oe` then falls at that frame-end tick.
- R8: If the enable goes low and returns high before the stop bit of the current frame ends, exactly one idle character follows that frame, and then any waiting byte is sent.
- R9: If the enable is low when a frame ends, a byte waiting in the holding register is discarded (`buf_empty` = 1). A later re-enable sends only the preamble.
- R10: With no frame in progress, a low enable releases the pin on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable |
| mode9 | input | 1 | 1 selects 9 data bits; sampled when a frame or idle character starts |
| wr_strobe | input | 1 | Write pulse for the holding register |
| wr_data | input | BASE_W+1 | Data to transmit (upper bit used only with mode9) |
| tx_line | output | 1 | Serial output level |
| tx_oe | output | 1 | 1 while the block drives the pin |
| buf_empty | output | 1 | Holding register may be written |

## Verification
Frames with 8-bit data are tried with all 256 data values sent back to back. This separates bit-order, bit-count and stop-bit faults, and it also shows any gap between frames. A 9-bit sweep with the top bit both set and clear confirms the wider frame and its extra idle bit.

Enable patterns cover four cases:
- enable with data already waiting;
- a short dip during a frame (queued idle);
- a drop held past the stop bit (pin release and discard, then a preamble with nothing after it);
- a drop while idle.

Together these tell apart the queued-idle path, the release path and the discard path.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLECH = 2'd1,
        ST_READY  = 2'd2,
        ST_SEND   = 2'd3
    } tx_state_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    input  logic          drop,
    output logic [DW-1:0] data,
    output logic          empty
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            data  <= wdata;
            empty <= 1'b0;
        end else if (take || drop) begin
            empty <= 1'b1;
        end
    end

    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int FW = 11,
    parameter int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] pattern,
    input  logic [CW-1:0] last_idx,
    input  logic          step,
    output logic          ser_out,
    output logic          at_last
);
    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            last <= '0;
        end else if (load) begin
            sh   <= pattern;
            cnt  <= '0;
            last <= last_idx;
        end else if (step) begin
            sh  <= {1'b1, sh[FW-1:1]};
            cnt <= cnt + 1'b1;
        end
    end

    assign ser_out = sh[0];
    assign at_last = (cnt == last);
endmodule

// File: rtl/sertx_idle.sv
module sertx_idle
    import sertx_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            tx_en,
    input  logic            mode9,
    input  logic            wr_strobe,
    input  logic [BASE_W:0] wr_data,
    output logic            tx_line,
    output logic            tx_oe,
    output logic            buf_empty
);
    localparam int DW = BASE_W + 1;
    localparam int FW = BASE_W + 3;
    localparam int CW = $clog2(FW + 1);

    tx_state_t       state, nxt;
    logic            load_frame, load_idle, drop, step;
    logic            saw_off, ser_out, at_last;
    logic [DW-1:0]   hold_data;
    logic [FW-1:0]   frame_pat, sh_pat;
    logic [CW-1:0]   len_last;

    sertx_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(wr_strobe), .wdata(wr_data),
        .take(load_frame), .drop(drop), .data(hold_data), .empty(buf_empty)
    );

    assign len_last = mode9 ? CW'(FW - 1) : CW'(FW - 2);

    always_comb begin
        frame_pat    = '1;
        frame_pat[0] = 1'b0;
        if (mode9) frame_pat[DW:1] = hold_data;
        else       frame_pat[BASE_W:1] = hold_data[BASE_W-1:0];
    end

    assign sh_pat = load_frame ? frame_pat : '1;
    assign step   = bit_tick && (state == ST_IDLECH || state == ST_SEND) && !at_last;

    sertx_shift #(.FW(FW), .CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_frame || load_idle),
        .pattern(sh_pat), .last_idx(len_last), .step(step),
        .ser_out(ser_out), .at_last(at_last)
    );

    always_comb begin
        nxt        = state;
        load_frame = 1'b0;
        load_idle  = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (bit_tick && tx_en) begin
                    nxt       = ST_IDLECH;
                    load_idle = 1'b1;
                end
            end
            ST_IDLECH: begin
                if (bit_tick && at_last) begin
                    if (!tx_en) nxt = ST_OFF;
                    else if (!buf_empty) begin
                        nxt        = ST_SEND;
                        load_frame = 1'b1;
                    end else nxt = ST_READY;
                end
            end
            ST_READY: begin
                if (!tx_en) nxt = ST_OFF;
                else if (bit_tick && !buf_empty) begin
                    nxt        = ST_SEND;
                    load_frame = 1'b1;
                end
            end
            ST_SEND: begin
                if (bit_tick && at_last) begin
                    if (!tx_en) nxt = ST_OFF;
                    else if (saw_off) begin
                        nxt       = ST_IDLECH;
                        load_idle = 1'b1;
                    end else if (!buf_empty) begin
                        nxt        = ST_SEND;
                        load_frame = 1'b1;
                    end else nxt = ST_READY;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end

    assign drop = (nxt == ST_OFF) && (state != ST_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            saw_off <= 1'b0;
        end else begin
            state <= nxt;
            if (load_frame)                     saw_off <= 1'b0;
            else if (state == ST_SEND && !tx_en) saw_off <= 1'b1;
        end
    end

    always_comb begin
        tx_oe   = (state != ST_OFF);
        tx_line = (state == ST_IDLECH || state == ST_SEND) ? ser_out : 1'b1;
    end

    a_r1_released_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_line);
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load_frame |=> !tx_line);
    a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !bit_tick) |=> $stable(tx_line));
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLECH |-> tx_line);
    a_r5_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load_frame && !wr_strobe) |=> buf_empty);
    a_r10_quick_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !tx_en) |=> !tx_oe);
endmodule

// File: tb/sertx_idle_bench.sv
`timescale 1ns/1ps
module sertx_idle_bench;
    logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, tx_en = 1'b0, mode9 = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_line, tx_oe, buf_empty;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    sertx_idle u_sertx_idle (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .mode9(mode9),
        .wr_strobe(wr_strobe), .wr_data(wr_data),
        .tx_line(tx_line), .tx_oe(tx_oe), .buf_empty(buf_empty)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fr(input logic [8:0] d, input bit m);
        logic [15:0] v;
        v    = '1;
        v[0] = 1'b0;
        for (int i = 0; i < 8 + m; i++) v[i+1] = d[i];
        return v;
    endfunction

    task automatic cap(input int n, output logic [15:0] v, output bit oe_all);
        v = '1;
        oe_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            v[i] = tx_line;
            if (!tx_oe) oe_all = 1'b0;
        end
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk) begin wr_strobe = 1'b1; wr_data = d; end
        @(negedge clk) wr_strobe = 1'b0;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        bit          oe, oe2;
        repeat (3) @(negedge clk);
        chk(tx_oe == 0 && tx_line == 1 && buf_empty == 1, "R1 reset", {tx_oe, tx_line, buf_empty}, 16'h3);
        rst_n = 1'b1;
        cap(3, v, oe);
        chk(!oe && v == 16'hFFFF, "R1 disabled ticks", v, 16'hFFFF);

        // R4 preamble with a byte already waiting, then R6 handoff
        wr(9'h03C);
        chk(buf_empty == 0, "R5 write clears empty", buf_empty, 0);
        tx_en = 1'b1;
        cap(10, v, oe);
        chk(oe && v == 16'hFFFF, "R4 preamble", v, 16'hFFFF);
        cap(10, v, oe);
        chk(oe && v == fr(9'h03C, 0), "R6 frame after preamble", v, fr(9'h03C, 0));

        // R2/R6 back-to-back sweep, 8-bit
        for (int d = 0; d < 256; d++) begin
            wr(9'(d));
            chk(buf_empty == 0, "R5 write", buf_empty, 0);
            cap(10, v, oe);
            chk(oe && v == fr(9'(d), 0), "R2 8-bit frame", v, fr(9'(d), 0));
            chk(buf_empty == 1, "R5 load sets empty", buf_empty, 1);
        end
        // 9-bit sweep
        mode9 = 1'b1;
        for (int k = 0; k < 32; k++) begin
            logic [8:0] d9;
            d9 = 9'((k * 83 + 5) % 512);
            if (k == 0) d9 = 9'h100;
            if (k == 1) d9 = 9'h0FF;
            wr(d9);
            cap(11, v, oe);
            chk(oe && v == fr(d9, 1), "R2 9-bit frame", v, fr(d9, 1));
        end
        cap(2, v, oe);
        chk(oe && v == 16'hFFFF, "R6 idle line after last frame", v, 16'hFFFF);
        mode9 = 1'b0;

        // R8 toggle during frame
        wr(9'h0A5);
        cap(3, v, oe);
        @(negedge clk) tx_en = 1'b0;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        wr(9'h05A);
        cap(7, v2, oe2);
        v[15:3] = v2[12:0];
        chk(oe && oe2 && v == fr(9'h0A5, 0), "R8 frame completes", v, fr(9'h0A5, 0));
        cap(10, v, oe);
        chk(oe && v == 16'hFFFF, "R8 queued idle", v, 16'hFFFF);
        cap(10, v, oe);
        chk(oe && v == fr(9'h05A, 0), "R8 data after idle", v, fr(9'h05A, 0));

        // R7/R9 disable held past stop bit
        wr(9'h0C3);
        cap(4, v, oe);
        @(negedge clk) tx_en = 1'b0;
        wr(9'h099);
        cap(6, v2, oe2);
        v[15:4] = v2[11:0];
        chk(oe && oe2 && v == fr(9'h0C3, 0), "R7 frame finishes", v, fr(9'h0C3, 0));
        cap(1, v, oe);
        chk(!oe && tx_line == 1, "R7 released after frame", oe, 0);
        chk(buf_empty == 1, "R9 waiting byte discarded", buf_empty, 1);
        tx_en = 1'b1;
        cap(10, v, oe);
        chk(oe && v == 16'hFFFF, "R9 preamble on re-enable", v, 16'hFFFF);
        cap(4, v, oe);
        chk(oe && v == 16'hFFFF, "R9 nothing sent after preamble", v, 16'hFFFF);

        // R10 drop while idle
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        chk(tx_oe == 0 && tx_line == 1, "R10 release when idle", tx_oe, 0);

        // R3 idle length with 9-bit mode
        mode9 = 1'b1;
        wr(9'h1E1);
        tx_en = 1'b1;
        cap(11, v, oe);
        chk(oe && v == 16'hFFFF, "R3 11-bit preamble", v, 16'hFFFF);
        cap(11, v, oe);
        chk(oe && v == fr(9'h1E1, 1), "R3 frame right after 11-bit idle", v, fr(9'h1E1, 1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule